// File: doc/BRIEF.md
# Chained Transfer Descriptor Loader

This block sits beside a DMA channel engine. It loads the channel's working registers from a four-word transfer descriptor held in memory. The engine asks for a load and hands over a descriptor pointer. The loader then reads the descriptor one word at a time over a simple request/valid read port. Only one read is outstanding at any moment.

From the control word it takes four transfer flags and a total-size field. It also takes an end-of-list bit. That bit tells the engine whether another descriptor should be chained when the current transfer completes. The other three words supply the next pointer, the source address and the destination address.

When a chained transfer ends and size writeback is enabled, the engine can ask the loader to rewrite the total-size field with the count of words still outstanding. The upper, non-total bits of the size register, which hold the chunk size, always follow the engine's `size_in` value.

Top module: `desc_chain_loader`

## Requirements
- R1: After a load, `more` equals the inverse of bit 20 of the control word, where bit 20 is the end-of-list flag.
- R2: A load reads pointer+0x0 (control), then pointer+0x4 (next pointer), then pointer+0x8 (source), then pointer+0xC (destination). `rd_req` stays high with a stable `rd_addr` until `rd_valid` returns, and the next word is requested in the following cycle.
- R3: `xfer_flags[3:0]` are loaded from control-word bits 19:16, in this order: bit 16 is source increment, bit 17 is destination increment, bit 18 is source select and bit 19 is destination select.
- R4: On a load, `size_out[TOT_W-1:0]` takes control-word bits [TOT_W-1:0]. The upper bits of `size_out` take `size_in`'s upper bits.
- R5: `src_addr` takes the word at offset 0x8 and `dst_addr` takes the word at offset 0xC.
- R6: `active_ptr` takes the pointer of the load request, and `next_ptr` takes the word at offset 0x4.
- R7: `done` is high for exactly one cycle, in the cycle after the destination word is captured. All loaded outputs already hold their new values in that cycle.
- R8: When the loader is idle and `wb_req` arrives with both `wb_en` and `list_mode` high, `size_out`'s total field becomes its previous value minus `wb_count`. The upper bits take `size_in`'s upper bits, and the result is visible one cycle later.
- R9: A `wb_req` arriving while `wb_en` or `list_mode` is low leaves `size_out` unchanged.
- R10: A `ld_req` arriving during a load is ignored. When `ld_req` and `wb_req` arrive in the same idle cycle, the load wins and the writeback is dropped.
- R11: Reset clears every output to zero, with `rd_req` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | Load request pulse |
| ld_ptr | input | AW | Descriptor pointer for the load |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Memory read address |
| rd_valid | input | 1 | Read data valid, which also completes the read |
| rd_data | input | DW | Read data |
| size_in | input | DW | Current channel size register (upper bits kept) |
| list_mode | input | 1 | Channel is in chained-list mode |
| wb_en | input | 1 | Size writeback enabled |
| wb_req | input | 1 | Writeback request at final completion |
| wb_count | input | TOT_W | Words already transferred |
| done | output | 1 | Load-complete pulse |
| more | output | 1 | Another descriptor follows |
| xfer_flags | output | 4 | Increment and select flags |
| size_out | output | DW | Updated channel size register |
| src_addr | output | AW | Loaded source address |
| dst_addr | output | AW | Loaded destination address |
| next_ptr | output | AW | Pointer to the following descriptor |
| active_ptr | output | AW | Pointer of the descriptor just loaded |

## Verification
The bench varies the read latency from zero to several cycles. A loader that advanced its word index without a valid, or that dropped the request early, would read the wrong offsets and load swapped addresses. A second load request is sent in the middle of a load. A loader that accepted it would jump to the new pointer and report the wrong `active_ptr`. Writeback is tried with each enable low, and also in the same cycle as a load request. A wrong gate would corrupt the total-size field, and a wrong priority would overwrite a freshly loaded size. A control word with every bit set checks that unrelated bits do not leak into the flags or into the upper size bits.

// File: rtl/dl_pkg.sv
package dl_pkg;
   localparam int CTL_FLAG_LSB = 16;
   localparam int NFLAG        = 4;
   localparam int CTL_EOL_BIT  = 20;

   typedef enum logic [1:0] {
      W_CTL = 2'd0,
      W_NXT = 2'd1,
      W_A0  = 2'd2,
      W_A1  = 2'd3
   } word_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_READ = 2'd1,
      S_FIN  = 2'd2
   } ld_state_t;
endpackage

// File: rtl/dl_fetch_seq.sv
module dl_fetch_seq
   import dl_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_req,
   input  logic [AW-1:0] ld_ptr,
   input  logic          rd_valid,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   output logic          cap_en,
   output logic [1:0]    cap_sel,
   output logic          last_cap,
   output logic          done,
   output logic          idle,
   output logic [AW-1:0] base_ptr
);
   ld_state_t     st;
   logic [1:0]    idx;
   logic [AW-1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         idx  <= '0;
         base <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (ld_req) begin
               base <= ld_ptr;
               idx  <= '0;
               st   <= S_READ;
            end
            S_READ: if (rd_valid) begin
               if (idx == W_A1) st <= S_FIN;
               else             idx <= idx + 2'd1;
            end
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign rd_req   = (st == S_READ);
   assign rd_addr  = base + AW'({idx, 2'b00});
   assign cap_en   = rd_req & rd_valid;
   assign cap_sel  = idx;
   assign last_cap = cap_en & (idx == W_A1);
   assign done     = (st == S_FIN);
   assign idle     = (st == S_IDLE);
   assign base_ptr = base;
endmodule

// File: rtl/dl_word_latch.sv
module dl_word_latch
   import dl_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TOT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [1:0]       cap_sel,
   input  logic             last_cap,
   input  logic [DW-1:0]    rd_data,
   input  logic [AW-1:0]    base_ptr,
   output logic [NFLAG-1:0] flags,
   output logic             more,
   output logic [AW-1:0]    src_addr,
   output logic [AW-1:0]    dst_addr,
   output logic [AW-1:0]    next_ptr,
   output logic [AW-1:0]    active_ptr,
   output logic [TOT_W-1:0] ld_total
);
   logic [TOT_W-1:0] tot_q;
   logic [NFLAG-1:0] flg_q;
   logic             eol_q;
   logic [AW-1:0]    nxt_q;
   logic [AW-1:0]    a0_q;

   // staging of the first three words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot_q <= '0;
         flg_q <= '0;
         eol_q <= 1'b0;
         nxt_q <= '0;
         a0_q  <= '0;
      end else if (cap_en && !last_cap) begin
         unique case (cap_sel)
            W_CTL: begin
               tot_q <= rd_data[TOT_W-1:0];
               flg_q <= rd_data[CTL_FLAG_LSB +: NFLAG];
               eol_q <= rd_data[CTL_EOL_BIT];
            end
            W_NXT:   nxt_q <= rd_data[AW-1:0];
            W_A0:    a0_q  <= rd_data[AW-1:0];
            default: ;
         endcase
      end
   end

   // commit at the edge that captures the final word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         more       <= 1'b0;
         src_addr   <= '0;
         dst_addr   <= '0;
         next_ptr   <= '0;
         active_ptr <= '0;
      end else if (last_cap) begin
         more       <= ~eol_q;
         src_addr   <= a0_q;
         dst_addr   <= rd_data[AW-1:0];
         next_ptr   <= nxt_q;
         active_ptr <= base_ptr;
      end
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flags[i] <= 1'b0;
         else if (last_cap) flags[i] <= flg_q[i];
      end
   end

   assign ld_total = tot_q;
endmodule

// File: rtl/dl_size_reg.sv
module dl_size_reg #(
   parameter int DW    = 32,
   parameter int TOT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_stb,
   input  logic [TOT_W-1:0] load_total,
   input  logic             wb_stb,
   input  logic [TOT_W-1:0] wb_count,
   input  logic [DW-1:0]    size_in,
   output logic [DW-1:0]    size_out
);
   localparam int HI_W = DW - TOT_W;

   logic [DW-1:0]   size_q;
   logic [HI_W-1:0] hi_keep;

   assign hi_keep = size_in[DW-1:TOT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        size_q <= '0;
      else if (load_stb) size_q <= {hi_keep, load_total};
      else if (wb_stb)   size_q <= {hi_keep, size_q[TOT_W-1:0] - wb_count};
   end

   assign size_out = size_q;
endmodule

// File: rtl/desc_chain_loader.sv
module desc_chain_loader
   import dl_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int TOT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_req,
   input  logic [AW-1:0]    ld_ptr,
   output logic             rd_req,
   output logic [AW-1:0]    rd_addr,
   input  logic             rd_valid,
   input  logic [DW-1:0]    rd_data,
   input  logic [DW-1:0]    size_in,
   input  logic             list_mode,
   input  logic             wb_en,
   input  logic             wb_req,
   input  logic [TOT_W-1:0] wb_count,
   output logic             done,
   output logic             more,
   output logic [NFLAG-1:0] xfer_flags,
   output logic [DW-1:0]    size_out,
   output logic [AW-1:0]    src_addr,
   output logic [AW-1:0]    dst_addr,
   output logic [AW-1:0]    next_ptr,
   output logic [AW-1:0]    active_ptr
);
   if (AW > DW) begin : g_bad_aw
      $error("desc_chain_loader: AW must not exceed DW");
   end
   if (TOT_W < 1 || TOT_W > CTL_FLAG_LSB) begin : g_bad_tot
      $error("desc_chain_loader: TOT_W must fit below the flag field");
   end
   if (CTL_EOL_BIT >= DW) begin : g_bad_dw
      $error("desc_chain_loader: DW too narrow for the control word");
   end

   logic             cap_en;
   logic [1:0]       cap_sel;
   logic             last_cap;
   logic             idle;
   logic [AW-1:0]    base_ptr;
   logic [TOT_W-1:0] ld_total;
   logic             wb_stb;

   dl_fetch_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_ptr(ld_ptr),
      .rd_valid(rd_valid), .rd_req(rd_req), .rd_addr(rd_addr),
      .cap_en(cap_en), .cap_sel(cap_sel), .last_cap(last_cap),
      .done(done), .idle(idle), .base_ptr(base_ptr)
   );

   dl_word_latch #(.AW(AW), .DW(DW), .TOT_W(TOT_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_sel(cap_sel),
      .last_cap(last_cap), .rd_data(rd_data), .base_ptr(base_ptr),
      .flags(xfer_flags), .more(more), .src_addr(src_addr),
      .dst_addr(dst_addr), .next_ptr(next_ptr), .active_ptr(active_ptr),
      .ld_total(ld_total)
   );

   // a load request in the same idle cycle takes precedence
   assign wb_stb = idle & ~ld_req & wb_req & wb_en & list_mode;

   dl_size_reg #(.DW(DW), .TOT_W(TOT_W)) u_size (
      .clk(clk), .rst_n(rst_n), .load_stb(last_cap), .load_total(ld_total),
      .wb_stb(wb_stb), .wb_count(wb_count), .size_in(size_in),
      .size_out(size_out)
   );
endmodule

// File: rtl/dl_chk.sv
module dl_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_req,
   input logic          rd_req,
   input logic [AW-1:0] rd_addr,
   input logic          rd_valid,
   input logic          eol_bit,
   input logic          done,
   input logic          more,
   input logic [AW-1:0] active_ptr,
   input logic [DW-1:0] size_out,
   input logic          wb_req,
   input logic          wb_en,
   input logic          list_mode
);
   logic [1:0]    cnt;
   logic [AW-1:0] first_addr;
   logic          eol_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         first_addr <= '0;
         eol_seen   <= 1'b0;
      end else if (rd_req && rd_valid) begin
         cnt <= cnt + 2'd1;
         if (cnt == 2'd0) begin
            first_addr <= rd_addr;
            eol_seen   <= eol_bit;
         end
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_valid |=> rd_req && $stable(rd_addr)); // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_valid && cnt != 2'd3 |=> rd_req && rd_addr == $past(rd_addr) + AW'(4)); // R2
   AST_NO_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_req); // R2
   AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_valid && cnt == 2'd3 |=> done); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_MORE_EOL: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> more == !eol_seen); // R1
   AST_ACTIVE_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> active_ptr == first_addr); // R6
   AST_WB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !(wb_en && list_mode) && !rd_req && !done && !ld_req |=> $stable(size_out)); // R9
endmodule

bind desc_chain_loader dl_chk #(.AW(AW), .DW(DW)) u_dl_chk (
   .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .rd_req(rd_req),
   .rd_addr(rd_addr), .rd_valid(rd_valid),
   .eol_bit(rd_data[dl_pkg::CTL_EOL_BIT]), .done(done), .more(more),
   .active_ptr(active_ptr), .size_out(size_out), .wb_req(wb_req),
   .wb_en(wb_en), .list_mode(list_mode)
);

// File: tb/test_desc_chain_loader.sv
module test_desc_chain_loader;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int TOT_W = 12;

   logic clk, rst_n, ld_req, rd_req, rd_valid, list_mode, wb_en, wb_req, done, more;
   logic [AW-1:0] ld_ptr, rd_addr, src_addr, dst_addr, next_ptr, active_ptr;
   logic [DW-1:0] rd_data, size_in, size_out;
   logic [TOT_W-1:0] wb_count;
   logic [3:0] xfer_flags;

   desc_chain_loader #(.AW(AW), .DW(DW), .TOT_W(TOT_W)) i_desc_chain_loader (
      .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_ptr(ld_ptr),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .size_in(size_in), .list_mode(list_mode), .wb_en(wb_en), .wb_req(wb_req),
      .wb_count(wb_count), .done(done), .more(more), .xfer_flags(xfer_flags),
      .size_out(size_out), .src_addr(src_addr), .dst_addr(dst_addr),
      .next_ptr(next_ptr), .active_ptr(active_ptr)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cycles = 0, lat = 0, wcnt = 0;
   logic [31:0] mem [logic [31:0]];

   // behavioural reference
   int m_state = 0, m_idx = 0;
   logic [31:0] m_ptr, w_ctl, w_nxt, w_a0;
   logic [31:0] e_size, e_src, e_dst, e_next, e_act;
   logic [3:0]  e_flags;
   logic        e_more;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_idx = 0; m_ptr = 0;
         w_ctl = 0; w_nxt = 0; w_a0 = 0;
         e_size = 0; e_src = 0; e_dst = 0; e_next = 0; e_act = 0;
         e_flags = 0; e_more = 0;
      end else begin
         if (m_state == 0) begin
            if (ld_req) begin
               m_ptr = ld_ptr; m_idx = 0; m_state = 1;
            end else if (wb_req && wb_en && list_mode) begin
               e_size = {size_in[31:12], 12'(e_size[11:0] - wb_count)};
            end
         end else if (m_state == 1) begin
            if (rd_valid) begin
               if (m_idx == 0) w_ctl = rd_data;
               else if (m_idx == 1) w_nxt = rd_data;
               else if (m_idx == 2) w_a0 = rd_data;
               else begin
                  e_flags = w_ctl[19:16];
                  e_more  = !w_ctl[20];
                  e_size  = {size_in[31:12], w_ctl[11:0]};
                  e_src   = w_a0;
                  e_dst   = rd_data;
                  e_next  = w_nxt;
                  e_act   = m_ptr;
                  m_state = 2;
               end
               if (m_idx < 3) m_idx++;
            end
         end else begin
            m_state = 0;
         end
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk("R2", "rd_req", 32'(rd_req), 32'(m_state == 1));
      if (m_state == 1) chk("R2", "rd_addr", rd_addr, m_ptr + 32'(4 * m_idx));
      chk("R7", "done", 32'(done), 32'(m_state == 2));
      chk("R3", "xfer_flags", 32'(xfer_flags), 32'(e_flags));
      chk("R1", "more", 32'(more), 32'(e_more));
      chk("R4 R8", "size_out", size_out, e_size);
      chk("R5", "src_addr", src_addr, e_src);
      chk("R5", "dst_addr", dst_addr, e_dst);
      chk("R6", "next_ptr", next_ptr, e_next);
      chk("R6", "active_ptr", active_ptr, e_act);
   endtask

   task automatic cyc();
      @(negedge clk);
      check_all();
      ld_req = 1'b0;
      wb_req = 1'b0;
      if (rd_req) begin
         if (wcnt >= lat) begin
            rd_valid = 1'b1;
            rd_data  = mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
            wcnt = 0;
         end else begin
            rd_valid = 1'b0;
            wcnt++;
         end
      end else begin
         rd_valid = 1'b0;
         wcnt = 0;
      end
   endtask

   task automatic do_load(input logic [31:0] ptr, input int l);
      lat = l;
      ld_req = 1'b1;
      ld_ptr = ptr;
      repeat (4 * (l + 1) + 4) cyc();
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         summary();
         $finish;
      end
   end

   initial begin
      mem[32'h100] = 32'h0005_0020; mem[32'h104] = 32'h0000_0200;
      mem[32'h108] = 32'h1000_0000; mem[32'h10C] = 32'h2000_0000;
      mem[32'h200] = 32'h001A_07FF; mem[32'h204] = 32'h0000_0340;
      mem[32'h208] = 32'hAAAA_0000; mem[32'h20C] = 32'hBBBB_0004;
      mem[32'h340] = 32'hFFFF_FFFF; mem[32'h344] = 32'hDEAD_BEE0;
      mem[32'h348] = 32'h1234_5678; mem[32'h34C] = 32'h9ABC_DEF0;

      rst_n = 1'b0; ld_req = 1'b0; ld_ptr = '0; rd_valid = 1'b0; rd_data = '0;
      size_in = 32'h0012_3000; list_mode = 1'b1; wb_en = 1'b1; wb_req = 1'b0;
      wb_count = '0;
      repeat (3) cyc();
      // R11 reset state
      chk("R11", "rd_req", 32'(rd_req), 0);
      chk("R11", "done", 32'(done), 0);
      chk("R11", "size_out", size_out, 0);
      chk("R11", "active_ptr", active_ptr, 0);
      rst_n = 1'b1;
      cyc();

      // back-to-back reads, chained descriptor
      do_load(32'h100, 0);
      chk("R1", "more after 0x100", 32'(more), 1);
      chk("R3", "flags after 0x100", 32'(xfer_flags), 32'h5);
      chk("R6", "next after 0x100", next_ptr, 32'h200);
      chk("R5", "src after 0x100", src_addr, 32'h1000_0000);

      // slow memory, second request while busy
      lat = 2;
      ld_req = 1'b1; ld_ptr = 32'h200;
      cyc(); cyc();
      ld_req = 1'b1; ld_ptr = 32'h340;
      repeat (20) cyc();
      chk("R10", "active ignores busy request", active_ptr, 32'h200);
      chk("R1", "more at end of list", 32'(more), 0);
      chk("R4", "size after 0x200", size_out, 32'h0012_37FF);

      // writeback enabled
      wb_count = 12'd5; wb_req = 1'b1;
      cyc(); cyc();
      chk("R8", "size after writeback", size_out, 32'h0012_37FA);

      // writeback gated by list mode, then by wb_en
      list_mode = 1'b0; wb_req = 1'b1;
      cyc(); cyc();
      chk("R9", "size with list mode off", size_out, 32'h0012_37FA);
      list_mode = 1'b1; wb_en = 1'b0; wb_req = 1'b1;
      cyc(); cyc();
      chk("R9", "size with writeback off", size_out, 32'h0012_37FA);

      // load and writeback in the same cycle, new chunk bits
      wb_en = 1'b1; size_in = 32'hABCD_E000; wb_req = 1'b1; wb_count = 12'd3;
      do_load(32'h340, 1);
      chk("R10", "load beats writeback", size_out, 32'hABCD_EFFF);
      chk("R3", "flags all set", 32'(xfer_flags), 32'hF);
      chk("R5", "dst after 0x340", dst_addr, 32'h9ABC_DEF0);
      chk("R6", "next after 0x340", next_ptr, 32'hDEAD_BEE0);
      chk("R7", "done low after load", 32'(done), 0);

      // writeback immediately after a load
      wb_req = 1'b1; wb_count = 12'hFFF;
      cyc(); cyc();
      chk("R8", "writeback to zero", size_out, 32'hABCD_E000);

      summary();
      $finish;
   end
endmodule